// File: doc/BRIEF.md
# PHY Tuning-Parameter Bring-Up Sequencer

This block brings a serial-link PHY out of reset without software help. On a start pulse it becomes master of a simple memory-mapped register bus. Over that bus it reaches four registers: a clock-control register, a test-input register, a test-output register and a PHY reset register. It first sets the port-select field of the clock-control register. It then programs four internal tuning fields in each PHY instance. The PHY's internal registers are not directly mapped, so every access goes through a packed test-input word with a separate write-enable bit. The data comes back through the test-output register.

Each field update is a read-modify-write. The sequencer requests a read of the PHY register and captures the byte. It merges the new field value under its mask and commits the word with a low/high/low toggle of the write-enable bit. It finishes with a dummy readback of the same register. Every test-input write is followed by two discarded test-output reads.

After the tuning fields are programmed, the block waits a settle time derived from the clock frequency. It then releases the PHY reset and waits the same time again before pulsing done. A legacy mode input limits the run to the port-select update. A dual mode input programs a second PHY instance that lives in the upper half of the test words. A separate shutdown pulse puts the PHY back into reset.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `busReq` are all low, and no bus access is made until a start or shutdown pulse arrives.
- R2: A start first reads the clock-control register. It then writes the register back with bits 11:9 equal to 1 and every other bit unchanged. In non-legacy mode this happens before any test-input access.
- R3: A test-input word carries the write-enable bit in bit 0, the 5-bit PHY register address in bits 5:1 and the 8-bit data in bits 13:6. For the second PHY instance the whole word is shifted left by 16 bits, and the readback byte is taken from test-output bits 23:16 instead of bits 7:0.
- R4: Every write to the test-input register is followed by exactly two test-output reads before any other access. Their data is discarded.
- R5: A PHY register is read by writing a test-input word whose data field is 1, then reading test-output. The new value is the read byte with the field's mask bits cleared and the new field value ORed in under the same mask.
- R6: Each update writes the merged word three times, with write-enable 0, then 1, then 0. This gives exactly one write-enable rising edge per field. It then writes a read word (data 1) for the same address and makes one more discarded test-output read. Each field therefore costs five test-input writes.
- R7: For each instance, the fields are programmed in this order: register 0 bit 3 set to 1, register 6 bits 5:0 set to 0, register 26 bits 7:4 set to 5, register 28 bits 3:2 set to 0. Instance 0 is done first. Instance 1 is programmed only in dual mode; otherwise it is left untouched.
- R8: After programming, the block waits at least `CLK_FREQ_HZ`/1e6 cycles. It then read-modify-writes the reset register to set bits 8 and 0, keeping all other bits. It waits at least the same time again before `done`.
- R9: In legacy mode, a start performs only the clock-control read and write. It makes no test-input, test-output or reset-register access.
- R10: A shutdown in non-legacy mode read-modify-writes the reset register, setting bit 8 and clearing bit 0 with the other bits kept. A shutdown in legacy mode makes no bus access. Both end with a `done` pulse.
- R11: `done` is a one-cycle pulse raised once per operation, with `busy` low. Start and shutdown pulses that arrive while busy are ignored.
- R12: Once `busReq` is raised, the request, address, direction and write data hold steady until the cycle in which `busAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches the bring-up run |
| shutdown | input | 1 | One-cycle pulse that puts the PHY back into reset |
| legacyMode | input | 1 | Limits a run to the port-select update; sampled at the pulse |
| dualMode | input | 1 | Programs the second PHY instance too; sampled at the pulse |
| busReq | output | 1 | Bus request, held until acknowledged |
| busWrite | output | 1 | 1 for a write, 0 for a read |
| busAddr | output | ADDR_W | Register offset |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Completes the current access |
| busRdata | input | 32 | Read data, valid with `busAck` |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The bench builds the block with a 50 MHz `CLK_FREQ_HZ`, which makes each settle window 50 cycles, and with the default register offsets. This keeps both delay gaps short enough to measure directly. The bus model varies its acknowledge latency from zero to three wait cycles per vector. Together these expose request-hold faults and the ordering of dummy reads against captures. The PHY model gives the two instances complementary contents, so a wrong byte lane or a missing shift shows up as a wrong merged value.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;

  localparam int INST_SHIFT = 16;
  localparam int PSEL_LSB = 9;
  localparam int PSEL_W = 3;
  localparam int PSEL_VAL = 1;
  localparam int RST_MANUAL_BIT = 8;
  localparam int RST_RELEASE_BIT = 0;
  localparam logic [7:0] RDREQ_DATA = 8'd1;

  localparam logic [31:0] PSEL_MASK = 32'(((1 << PSEL_W) - 1) << PSEL_LSB);
  localparam logic [31:0] PSEL_WORD = 32'(PSEL_VAL << PSEL_LSB);
  localparam logic [31:0] RST_MANUAL = 32'(1) << RST_MANUAL_BIT;
  localparam logic [31:0] RST_RELEASE = 32'(1) << RST_RELEASE_BIT;

  typedef enum logic [1:0] {SEL_CLK, SEL_TIN, SEL_TOUT, SEL_RST} regSel_e;

  typedef enum logic [2:0] {
    W_NONE, W_CLKSEL, W_RDREQ, W_MRG_LO, W_MRG_HI, W_RST_ON, W_RST_OFF
  } wordSel_e;

  typedef struct packed {
    logic       req;
    logic       wr;
    regSel_e    sel;
    wordSel_e   word;
    logic       capWord;
    logic       capByte;
    logic       loadDly;
    logic       inst;
    logic [1:0] prm;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [4:0] addr;
    logic [7:0] mask;
    logic [7:0] val;
  } tuneEntry_t;

  function automatic tuneEntry_t tuneEntry(input logic [1:0] idx);
    tuneEntry_t e;
    case (idx)
      2'd0:    begin e.addr = 5'd0;  e.mask = 8'h08; e.val = 8'h08; end
      2'd1:    begin e.addr = 5'd6;  e.mask = 8'h3F; e.val = 8'h00; end
      2'd2:    begin e.addr = 5'd26; e.mask = 8'hF0; e.val = 8'h50; end
      default: begin e.addr = 5'd28; e.mask = 8'h0C; e.val = 8'h00; end
    endcase
    return e;
  endfunction

  function automatic logic [31:0] packTin(input logic [7:0] data, input logic [4:0] addr,
                                          input logic we, input logic inst);
    logic [31:0] w;
    w = {18'd0, data, addr, we};
    return inst ? (w << INST_SHIFT) : w;
  endfunction

endpackage

// File: rtl/phy_init_ctrl.sv
module phy_init_ctrl
  import phy_init_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        shutdown,
  input  logic        legacyMode,
  input  logic        dualMode,
  input  logic        busAck,
  input  logic        dlyDone,
  output ctrlStrobe_t cs,
  output logic        busy,
  output logic        done
);

  typedef enum logic [3:0] {
    S_IDLE, S_CLK_RD, S_CLK_WR, S_TI_WR, S_TO_DUM, S_TO_RD, S_DLY1, S_WAIT1,
    S_RST_RD, S_RST_WR, S_DLY2, S_WAIT2, S_DONE
  } state_e;

  state_e     state, stateNxt;
  logic [2:0] phase, phaseNxt;   // 0 read-req, 1 lo, 2 hi, 3 lo, 4 dummy read-req
  logic       dumQ, dumNxt;
  logic [1:0] prm, prmNxt;
  logic       inst, instNxt;
  logic       legacyQ, legacyNxt;
  logic       dualQ, dualNxt;
  logic       shutQ, shutNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= '0;
      dumQ    <= 1'b0;
      prm     <= '0;
      inst    <= 1'b0;
      legacyQ <= 1'b0;
      dualQ   <= 1'b0;
      shutQ   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNxt;
      phase   <= phaseNxt;
      dumQ    <= dumNxt;
      prm     <= prmNxt;
      inst    <= instNxt;
      legacyQ <= legacyNxt;
      dualQ   <= dualNxt;
      shutQ   <= shutNxt;
      done    <= (state == S_DONE);
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    stateNxt  = state;
    phaseNxt  = phase;
    dumNxt    = dumQ;
    prmNxt    = prm;
    instNxt   = inst;
    legacyNxt = legacyQ;
    dualNxt   = dualQ;
    shutNxt   = shutQ;
    case (state)
      S_IDLE: begin
        if (start) begin
          legacyNxt = legacyMode;
          dualNxt   = dualMode;
          shutNxt   = 1'b0;
          phaseNxt  = '0;
          prmNxt    = '0;
          instNxt   = 1'b0;
          dumNxt    = 1'b0;
          stateNxt  = S_CLK_RD;
        end else if (shutdown) begin
          legacyNxt = legacyMode;
          shutNxt   = 1'b1;
          stateNxt  = legacyMode ? S_DONE : S_RST_RD;
        end
      end
      S_CLK_RD: if (busAck) stateNxt = S_CLK_WR;
      S_CLK_WR: if (busAck) stateNxt = legacyQ ? S_DONE : S_TI_WR;
      S_TI_WR: if (busAck) begin
        dumNxt   = 1'b0;
        stateNxt = S_TO_DUM;
      end
      S_TO_DUM: if (busAck) begin
        if (!dumQ) dumNxt = 1'b1;
        else begin
          dumNxt = 1'b0;
          if (phase == 3'd0 || phase == 3'd4) stateNxt = S_TO_RD;
          else begin
            phaseNxt = phase + 3'd1;
            stateNxt = S_TI_WR;
          end
        end
      end
      S_TO_RD: if (busAck) begin
        stateNxt = S_TI_WR;
        if (phase == 3'd0) phaseNxt = 3'd1;
        else begin
          phaseNxt = 3'd0;
          if (prm == 2'd3) begin
            prmNxt = 2'd0;
            if (dualQ && !inst) instNxt = 1'b1;
            else stateNxt = S_DLY1;
          end else prmNxt = prm + 2'd1;
        end
      end
      S_DLY1:   stateNxt = S_WAIT1;
      S_WAIT1:  if (dlyDone) stateNxt = S_RST_RD;
      S_RST_RD: if (busAck) stateNxt = S_RST_WR;
      S_RST_WR: if (busAck) stateNxt = shutQ ? S_DONE : S_DLY2;
      S_DLY2:   stateNxt = S_WAIT2;
      S_WAIT2:  if (dlyDone) stateNxt = S_DONE;
      S_DONE:   stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    cs      = '0;
    cs.inst = inst;
    cs.prm  = prm;
    case (state)
      S_CLK_RD: begin cs.req = 1'b1; cs.sel = SEL_CLK; cs.capWord = 1'b1; end
      S_CLK_WR: begin cs.req = 1'b1; cs.wr = 1'b1; cs.sel = SEL_CLK; cs.word = W_CLKSEL; end
      S_TI_WR: begin
        cs.req = 1'b1;
        cs.wr  = 1'b1;
        cs.sel = SEL_TIN;
        if (phase == 3'd0 || phase == 3'd4) cs.word = W_RDREQ;
        else if (phase == 3'd2)             cs.word = W_MRG_HI;
        else                                cs.word = W_MRG_LO;
      end
      S_TO_DUM: begin cs.req = 1'b1; cs.sel = SEL_TOUT; end
      S_TO_RD:  begin cs.req = 1'b1; cs.sel = SEL_TOUT; cs.capByte = (phase == 3'd0); end
      S_DLY1, S_DLY2: cs.loadDly = 1'b1;
      S_RST_RD: begin cs.req = 1'b1; cs.sel = SEL_RST; cs.capWord = 1'b1; end
      S_RST_WR: begin
        cs.req  = 1'b1;
        cs.wr   = 1'b1;
        cs.sel  = SEL_RST;
        cs.word = shutQ ? W_RST_OFF : W_RST_ON;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/phy_init_dp.sv
module phy_init_dp
  import phy_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned CLK_OFS = 'h0000,
  parameter int unsigned TIN_OFS = 'h2000,
  parameter int unsigned TOUT_OFS = 'h2004,
  parameter int unsigned RST_OFS = 'h200C,
  parameter int DLY_CYC = 50,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       cs,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic              dlyDone
);

  logic [31:0]      wordQ;
  logic [7:0]       byteQ;
  logic [CNT_W-1:0] dlyCnt;
  tuneEntry_t       te;
  logic [7:0]       merged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ  <= '0;
      byteQ  <= '0;
      dlyCnt <= '0;
    end else begin
      if (cs.capWord && busAck) wordQ <= busRdata;
      if (cs.capByte && busAck) byteQ <= cs.inst ? busRdata[23:16] : busRdata[7:0];
      if (cs.loadDly)           dlyCnt <= CNT_W'(DLY_CYC);
      else if (dlyCnt != '0)    dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign dlyDone = (dlyCnt == '0);
  assign te      = tuneEntry(cs.prm);
  assign merged  = (byteQ & ~te.mask) | (te.val & te.mask);

  assign busReq   = cs.req;
  assign busWrite = cs.req & cs.wr;

  always_comb begin
    case (cs.sel)
      SEL_CLK:  busAddr = ADDR_W'(CLK_OFS);
      SEL_TIN:  busAddr = ADDR_W'(TIN_OFS);
      SEL_TOUT: busAddr = ADDR_W'(TOUT_OFS);
      default:  busAddr = ADDR_W'(RST_OFS);
    endcase
  end

  always_comb begin
    case (cs.word)
      W_CLKSEL:  busWdata = (wordQ & ~PSEL_MASK) | PSEL_WORD;
      W_RDREQ:   busWdata = packTin(RDREQ_DATA, te.addr, 1'b0, cs.inst);
      W_MRG_LO:  busWdata = packTin(merged, te.addr, 1'b0, cs.inst);
      W_MRG_HI:  busWdata = packTin(merged, te.addr, 1'b1, cs.inst);
      W_RST_ON:  busWdata = wordQ | RST_MANUAL | RST_RELEASE;
      W_RST_OFF: busWdata = (wordQ | RST_MANUAL) & ~RST_RELEASE;
      default:   busWdata = '0;
    endcase
  end

endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned CLK_OFS = 'h0000,
  parameter int unsigned TIN_OFS = 'h2000,
  parameter int unsigned TOUT_OFS = 'h2004,
  parameter int unsigned RST_OFS = 'h200C,
  parameter int unsigned CLK_FREQ_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              shutdown,
  input  logic              legacyMode,
  input  logic              dualMode,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              busy,
  output logic              done
);

  localparam int DLY_RAW = int'((CLK_FREQ_HZ + 999_999) / 1_000_000);
  localparam int DLY_CYC = (DLY_RAW < 1) ? 1 : DLY_RAW;
  localparam int CNT_W   = $clog2(DLY_CYC + 1);

  ctrlStrobe_t cs;
  logic        dlyDone;

  phy_init_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .shutdown(shutdown),
    .legacyMode(legacyMode), .dualMode(dualMode), .busAck(busAck),
    .dlyDone(dlyDone), .cs(cs), .busy(busy), .done(done)
  );

  phy_init_dp #(
    .ADDR_W(ADDR_W), .CLK_OFS(CLK_OFS), .TIN_OFS(TIN_OFS), .TOUT_OFS(TOUT_OFS),
    .RST_OFS(RST_OFS), .DLY_CYC(DLY_CYC), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .busAck(busAck), .busRdata(busRdata),
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .dlyDone(dlyDone)
  );

endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int unsigned TIN_OFS = 'h2000,
  parameter int unsigned TOUT_OFS = 'h2004
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busAck,
  input logic              busy,
  input logic              done
);

  logic [1:0] pend;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= 2'd0;
    else if (busReq && busAck && busWrite && busAddr == ADDR_W'(TIN_OFS)) pend <= 2'd2;
    else if (busReq && busAck && pend != 2'd0) pend <= pend - 2'd1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);

  a_r12_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr) && $stable(busWrite) && $stable(busWdata));

  a_r4_dummy_reads: assert property (@(posedge clk) disable iff (!rstN)
    (pend != 2'd0 && busReq) |-> (!busWrite && busAddr == ADDR_W'(TOUT_OFS)));

  a_r3_one_inst: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == ADDR_W'(TIN_OFS)) |->
      (busWdata[31:16] == 16'd0 || busWdata[15:0] == 16'd0));

endmodule

bind phy_init_seq phy_init_seq_chk #(
  .ADDR_W(ADDR_W), .TIN_OFS(TIN_OFS), .TOUT_OFS(TOUT_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .busAck(busAck), .busy(busy), .done(done)
);

// File: tb/phy_init_seq_bench.sv
module phy_init_seq_bench;

  localparam int DLY = 50;
  localparam logic [15:0] CLK_A = 16'h0000;
  localparam logic [15:0] TIN_A = 16'h2000;
  localparam logic [15:0] TOUT_A = 16'h2004;
  localparam logic [15:0] RST_A = 16'h200C;
  // [31:24] fill, [23:20] latency, [17] legacy, [16] dual, [15:0] seed
  localparam int NV = 5;
  localparam logic [31:0] VECS [NV] = '{
    32'hA500_1234, 32'h3C21_F0F0, 32'hFF12_0E00, 32'h0031_FFFF, 32'h5A03_0000
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic start = 1'b0, shutdown = 1'b0, legacyMode = 1'b0, dualMode = 1'b0;
  logic busReq, busWrite, busy, done;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic busAck = 1'b0;
  logic [31:0] busRdata = '0;

  always #10 clk = ~clk;

  int checks = 0, errors = 0;

  phy_init_seq #(.CLK_FREQ_HZ(50_000_000)) u_phy_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .shutdown(shutdown),
    .legacyMode(legacyMode), .dualMode(dualMode), .busReq(busReq),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata), .busy(busy), .done(done)
  );

  // bus slave and PHY model
  logic preload = 1'b0;
  logic [31:0] preClk = '0, preRst = '0;
  logic [7:0] preFill = '0;
  int lat = 0;
  logic [31:0] regClk, regRst;
  logic [7:0] phyMem [2][32];
  logic [4:0] phyAdr [2];
  logic prevWe [2];
  int tinWr, rstAcc, viol, holdViol, pend, doneCnt, doneWide, waitCnt, cyc;
  int riseCnt [2];
  int lastToutAck, rstRdCyc, rstWrAck, doneCyc, commitN, anyAcc;
  logic [5:0] commitLog [8];
  logic [15:0] firstAddr, holdAddr;
  logic [31:0] holdData;
  logic holdWr, seenFirst, doneQ;

  always @(negedge clk) begin
    logic [31:0] half;
    cyc++;
    if (preload) begin
      regClk = preClk; regRst = preRst;
      for (int h = 0; h < 2; h++) begin
        for (int a = 0; a < 32; a++) phyMem[h][a] = (h == 1) ? ~preFill : preFill;
        phyAdr[h] = '0; prevWe[h] = 1'b0; riseCnt[h] = 0;
      end
      tinWr = 0; rstAcc = 0; viol = 0; holdViol = 0; pend = 0; waitCnt = 0;
      lastToutAck = 0; rstRdCyc = -1; rstWrAck = 0; commitN = 0; anyAcc = 0;
      seenFirst = 1'b0; firstAddr = '1; busAck = 1'b0;
    end else begin
      if (done) begin doneCnt++; doneCyc = cyc; if (doneQ) doneWide++; end
      doneQ = done;
      if (busAck) busAck = 1'b0;
      else if (busReq) begin
        if (!seenFirst) begin firstAddr = busAddr; seenFirst = 1'b1; end
        if (waitCnt == 0) begin holdAddr = busAddr; holdData = busWdata; holdWr = busWrite; end
        else if (holdAddr != busAddr || holdData != busWdata || holdWr != busWrite) holdViol++;
        if (busAddr == RST_A && !busWrite && rstRdCyc < 0) rstRdCyc = cyc;
        if (waitCnt >= lat) begin
          waitCnt = 0;
          busAck = 1'b1;
          anyAcc++;
          if (pend > 0) begin
            if (busWrite || busAddr != TOUT_A) viol++;
            pend--;
          end
          case (busAddr)
            CLK_A: if (busWrite) regClk = busWdata; else busRdata = regClk;
            TIN_A: if (busWrite) begin
              tinWr++; pend = 2;
              for (int h = 0; h < 2; h++) begin
                half = busWdata >> (16 * h);
                if (half[0] && !prevWe[h]) begin
                  phyMem[h][half[5:1]] = half[13:6];
                  riseCnt[h]++;
                  if (commitN < 8) commitLog[commitN] = {1'(h), half[5:1]};
                  commitN++;
                end
                prevWe[h] = half[0];
                phyAdr[h] = half[5:1];
              end
            end else busRdata = '0;
            TOUT_A: begin
              busRdata = {8'h00, phyMem[1][phyAdr[1]], 8'h00, phyMem[0][phyAdr[0]]};
              lastToutAck = cyc;
            end
            RST_A: begin
              rstAcc++;
              if (busWrite) begin regRst = busWdata; rstWrAck = cyc; end
              else busRdata = regRst;
            end
            default: viol++;
          endcase
        end else waitCnt++;
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(tag, act == exp, act, exp);
  endtask

  task automatic preset(input logic [31:0] c, input logic [31:0] r, input logic [7:0] f, input int l);
    @(posedge clk);
    preClk = c; preRst = r; preFill = f; lat = l; preload = 1'b1;
    @(posedge clk);
    preload = 1'b0;
  endtask

  task automatic runOp(input bit isStart, input bit leg, input bit dual, input bit intrude);
    int base;
    base = doneCnt;
    @(negedge clk);
    legacyMode = leg; dualMode = dual;
    if (isStart) start = 1'b1; else shutdown = 1'b1;
    @(negedge clk);
    start = 1'b0; shutdown = 1'b0;
    if (intrude) begin
      repeat (30) @(negedge clk);
      start = 1'b1; shutdown = 1'b1; legacyMode = 1'b1; dualMode = 1'b1;
      @(negedge clk);
      start = 1'b0; shutdown = 1'b0;
    end
    for (int t = 0; t < 20000 && doneCnt == base; t++) @(posedge clk);
    repeat (200) @(posedge clk);
  endtask

  function automatic logic [7:0] expField(input int idx, input logic [7:0] old);
    case (idx)
      0:       return old | 8'h08;
      1:       return old & 8'hC0;
      2:       return (old & 8'h0F) | 8'h50;
      default: return old & 8'hF3;
    endcase
  endfunction

  function automatic logic [4:0] fieldAddr(input int idx);
    case (idx)
      0: return 5'd0;
      1: return 5'd6;
      2: return 5'd26;
      default: return 5'd28;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doneCnt = 0; doneWide = 0; doneQ = 1'b0; cyc = 0;
    repeat (3) @(negedge clk);
    chkEq("R1 busy after reset", 32'(busy), 0);
    chkEq("R1 done after reset", 32'(done), 0);
    chkEq("R1 busReq after reset", 32'(busReq), 0);
    @(negedge clk) rstN = 1'b1;
    repeat (5) @(negedge clk);
    chkEq("R1 idle without command", 32'(busReq | busy), 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] fill;
      logic [31:0] ci, ri;
      bit leg, dual;
      int n, dBefore;
      fill = VECS[v][31:24];
      leg = VECS[v][17]; dual = VECS[v][16];
      ci = {VECS[v][15:0], VECS[v][15:0]};
      ri = {~VECS[v][15:0], VECS[v][15:0]};
      n = dual ? 2 : 1;
      preset(ci, ri, fill, int'(VECS[v][23:20]));
      dBefore = doneCnt;
      runOp(1'b1, leg, dual, 1'b0);
      chkEq("R11 one done per start", doneCnt - dBefore, 1);
      chkEq("R2 port select field", regClk, (ci & ~32'h0E00) | 32'h0200);
      chkEq("R2 first access is clock control", 32'(firstAddr), 32'(CLK_A));
      chkEq("R12 request held until ack", holdViol, 0);
      if (leg) begin
        chkEq("R9 no test-input writes", tinWr, 0);
        chkEq("R9 no reset register access", rstAcc, 0);
        chkEq("R9 phy untouched", 32'(phyMem[0][0]), 32'(fill));
      end else begin
        chkEq("R4 dummy reads after test-input write", viol, 0);
        chkEq("R6 five test-input writes per field", tinWr, 20 * n);
        for (int h = 0; h < 2; h++) begin
          logic [7:0] f;
          f = (h == 1) ? ~fill : fill;
          if (h < n) begin
            chkEq("R6 one write-enable edge per field", riseCnt[h], 4);
            for (int k = 0; k < 4; k++)
              chkEq("R5 R3 merged field value", 32'(phyMem[h][fieldAddr(k)]), 32'(expField(k, f)));
          end else begin
            chkEq("R7 second instance untouched", riseCnt[h], 0);
            chkEq("R7 second instance data kept", 32'(phyMem[h][26]), 32'(f));
          end
        end
        for (int k = 0; k < 4 * n; k++)
          chkEq("R7 commit order", 32'(commitLog[k]), 32'({1'(k / 4), fieldAddr(k % 4)}));
        chkEq("R8 reset released", regRst, ri | 32'h0000_0101);
        chk("R8 settle before release", (rstRdCyc - lastToutAck) >= DLY, 32'(rstRdCyc - lastToutAck), DLY);
        chk("R8 settle after release", (doneCyc - rstWrAck) >= DLY, 32'(doneCyc - rstWrAck), DLY);
      end
    end
    chkEq("R11 done never wider than one cycle", doneWide, 0);

    // commands while busy are ignored
    begin
      int dBefore;
      preset(32'h0, 32'h0, 8'h81, 1);
      dBefore = doneCnt;
      runOp(1'b1, 1'b0, 1'b0, 1'b1);
      chkEq("R11 single done with intruding pulses", doneCnt - dBefore, 1);
      chkEq("R11 intruding pulses change nothing", tinWr, 20);
      chkEq("R11 reset ends released", regRst, 32'h0000_0101);
    end

    // shutdown, non-legacy
    begin
      int dBefore;
      preset(32'h0, 32'h1234_5601, 8'h00, 2);
      dBefore = doneCnt;
      runOp(1'b0, 1'b0, 1'b0, 1'b0);
      chkEq("R10 shutdown reset value", regRst, 32'h1234_5700);
      chkEq("R10 shutdown no test access", tinWr, 0);
      chkEq("R10 shutdown reset accesses", rstAcc, 2);
      chkEq("R10 shutdown done", doneCnt - dBefore, 1);
    end

    // shutdown, legacy
    begin
      int dBefore;
      preset(32'h0, 32'h0000_0101, 8'h00, 0);
      dBefore = doneCnt;
      runOp(1'b0, 1'b1, 1'b0, 1'b0);
      chkEq("R10 legacy shutdown no access", anyAcc, 0);
      chkEq("R10 legacy shutdown keeps reset", regRst, 32'h0000_0101);
      chkEq("R10 legacy shutdown done", doneCnt - dBefore, 1);
    end
    chkEq("R11 done pulse width", doneWide, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule